// File: doc/BRIEF.md
# External Interrupt Trigger Aggregator

This block gathers up to 128 peripheral interrupt lines and presents them to the hardware threads of a processor core. Each line can be either edge- or level-sensitive. The block records a pending bit for each line, and a per-line enable decides whether that pending bit may reach the core. A per-line routing value chooses which thread's trigger the line drives, or disconnects the line entirely. Every thread has a single active-low, level-type trigger output. The output stays asserted for as long as any enabled, pending line is routed to that thread.

Lines are grouped in banks of 32. Software reaches the block over a simple synchronous word bus. Through that bus it reads the pending, sense, enable and routing state, and it writes them. Writing a 1 into a pending bit acknowledges or re-raises an edge line, and forces a level line high. This allows software to re-trigger an interrupt that it held back earlier.

Top module: `ext_irq_agg`

## Requirements
- R1: After reset, every pending, sense, enable and routing value is 0, every trigger output is 1 (inactive), and rdata_o is 0.
- R2: Address map, word accesses:
  - pending word of bank b is at 0x000+8*b;
  - sense word is at 0x040+8*b;
  - enable word is at 0x080+8*b;
  - routing value of line i in bank b is at 0x1000*(b+1)+4*i.
  A read places data on rdata_o at the edge that accepts it, and rdata_o holds that value until the next read. Unmapped addresses and banks at or above NUM_BANKS read as 0 and ignore writes.
- R3: Line n lives in bank n>>5 at bit n&31 of that bank's pending, sense and enable words.
- R4: Each line input passes through two synchronizer flops. A change on irq_i reaches the pending bit, and the trigger output, at the third rising clock edge after it is applied, and not before.
- R5: For an edge line (sense bit 0), a rising input sets the pending bit. A falling input leaves the pending bit unchanged.
- R6: For an edge line, writing 1 to its pending bit toggles that bit. 0 to 1 re-raises the interrupt, and 1 to 0 acknowledges it. Writing 0 has no effect.
- R7: If a synchronized rising edge and a toggle write hit the same edge line in the same cycle, the pending bit ends at 1.
- R8: For a level line (sense bit 1), the pending bit follows the synchronized input.
- R9: Writing 1 to a level line's pending bit forces it to 1 from the write edge onward. The force is released at the first later edge at which the synchronized input is low.
- R10: An enable bit of 0 keeps its line away from every trigger, but the pending bit is still recorded. Setting the enable bit lets an already pending line assert its trigger at once.
- R11: A routing value v in 1..NUM_THREADS connects the line to thread v-1. A value of 0, or any value above NUM_THREADS, disconnects the line.
- R12: trig_n_o[t] is 0 exactly while some line is pending, enabled and routed to thread t. It follows register writes in the cycle after the write edge, with no added delay.
- R13: A sense bit of 1 selects level detection and 0 selects edge detection. An edge line that is acknowledged while its input stays high is not raised again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_BANKS*32 | Peripheral interrupt lines, asynchronous |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 15 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| trig_n_o | output | NUM_THREADS | Per-thread trigger, active low |

## Verification
An input change is due on the pending state and trigger outputs at the third rising edge after it is applied. A register write shows on trig_n_o right after its own edge, and read data shows right after the edge that accepts the read. The bench drives all inputs on falling edges and counts rising edges explicitly before it samples on the next falling edge. For the input path it checks both the second edge (still quiet) and the third (changed). A sweep covers every line of a two-bank, four-thread configuration with all eight routing codes, and targeted sequences cover masking, forcing, toggling and the same-cycle collision.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned LPB    = 32;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 15;

  typedef enum logic [1:0] {
    KIND_STAT  = 2'd0,
    KIND_SENSE = 2'd1,
    KIND_MASK  = 2'd2,
    KIND_NONE  = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic      hit;
    logic      is_vec;
    reg_kind_e kind;
    logic [1:0] bank;
    logic [4:0] line;
  } dec_t;

  function automatic dec_t addr_decode(input logic [ADDR_W-1:0] a, input int unsigned nb);
    dec_t d;
    d = '0;
    d.kind = KIND_NONE;
    if (a[14:12] == 3'd0) begin
      d.kind = reg_kind_e'(a[7:6]);
      d.bank = a[4:3];
      d.hit  = (a[11:8] == 4'd0) && !a[5] && (a[2:0] == 3'd0) && (d.kind != KIND_NONE);
    end else begin
      d.is_vec = 1'b1;
      d.bank   = 2'(a[14:12] - 3'd1);
      d.line   = a[6:2];
      d.hit    = (a[14:12] <= 3'd4) && (a[11:7] == 5'd0) && (a[1:0] == 2'd0);
    end
    if (32'(d.bank) >= nb) d.hit = 1'b0;
    return d;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign q_o    = s2_q;
  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int unsigned LINES       = 32,
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned VEC_W       = 3
) (
  input  logic [LINES-1:0]       act_i,
  input  logic [LINES*VEC_W-1:0] vec_i,
  output logic [NUM_THREADS-1:0] req_o
);
  always_comb begin
    req_o = '0;
    for (int i = 0; i < LINES; i++) begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        if (act_i[i] && (vec_i[i*VEC_W +: VEC_W] == VEC_W'(t + 1))) req_o[t] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned VEC_W       = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [LPB-1:0]         lvl_i,
  input  logic [LPB-1:0]         rise_i,
  input  logic                   wr_stat_i,
  input  logic                   wr_sense_i,
  input  logic                   wr_mask_i,
  input  logic                   wr_vec_i,
  input  logic [4:0]             line_i,
  input  logic [BUS_W-1:0]       wdata_i,
  output logic [LPB-1:0]         stat_o,
  output logic [LPB-1:0]         sense_o,
  output logic [LPB-1:0]         mask_o,
  output logic [LPB*VEC_W-1:0]   vec_o,
  output logic [NUM_THREADS-1:0] req_o
);
  logic [LPB-1:0]       stat_q, stat_d, frc_q, frc_d, sense_q, mask_q, sw1;
  logic [LPB*VEC_W-1:0] vec_q;

  assign sw1 = wr_stat_i ? wdata_i : '0;

  always_comb begin
    for (int i = 0; i < LPB; i++) begin
      if (sense_q[i]) begin
        // force holds until a cycle with the input low
        frc_d[i]  = sw1[i] | (frc_q[i] & lvl_i[i]);
        stat_d[i] = lvl_i[i] | frc_d[i];
      end else begin
        // hardware set wins over a same-cycle toggle
        frc_d[i]  = 1'b0;
        stat_d[i] = rise_i[i] | (stat_q[i] ^ sw1[i]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      frc_q   <= '0;
      sense_q <= '0;
      mask_q  <= '0;
      vec_q   <= '0;
    end else begin
      stat_q <= stat_d;
      frc_q  <= frc_d;
      if (wr_sense_i) sense_q <= wdata_i;
      if (wr_mask_i)  mask_q  <= wdata_i;
      for (int i = 0; i < LPB; i++) begin
        if (wr_vec_i && (line_i == 5'(i))) vec_q[i*VEC_W +: VEC_W] <= wdata_i[VEC_W-1:0];
      end
    end
  end

  irq_route #(
    .LINES      (LPB),
    .NUM_THREADS(NUM_THREADS),
    .VEC_W      (VEC_W)
  ) u_route (
    .act_i(stat_q & mask_q),
    .vec_i(vec_q),
    .req_o(req_o)
  );

  assign stat_o  = stat_q;
  assign sense_o = sense_q;
  assign mask_o  = mask_q;
  assign vec_o   = vec_q;
endmodule

// File: rtl/ext_irq_agg.sv
module ext_irq_agg
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 2,
  parameter int unsigned NUM_THREADS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_BANKS*LPB-1:0]   irq_i,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [BUS_W-1:0]           wdata_i,
  output logic [BUS_W-1:0]           rdata_o,
  output logic [NUM_THREADS-1:0]     trig_n_o
);
  localparam int unsigned NUM_LINES = NUM_BANKS * LPB;
  localparam int unsigned VEC_W     = $clog2(NUM_THREADS + 1);

  logic [NUM_LINES-1:0] sync_all, rise_all, stat_all, sense_all, mask_all;
  logic [NUM_LINES*VEC_W-1:0] vec_all;

  logic [NUM_BANKS-1:0][LPB-1:0]         stat_b, sense_b, mask_b;
  logic [NUM_BANKS-1:0][LPB*VEC_W-1:0]   vec_b;
  logic [NUM_BANKS-1:0][NUM_THREADS-1:0] req_b;
  logic [NUM_THREADS-1:0] any_req;
  logic [BUS_W-1:0] rd_val;
  logic wr_hit;
  dec_t dec;

  assign dec    = addr_decode(addr_i, NUM_BANKS);
  assign wr_hit = req_i && we_i && dec.hit;

  irq_sync #(.W(NUM_LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (sync_all),
    .rise_o(rise_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = wr_hit && (dec.bank == 2'(b));

    irq_bank #(
      .NUM_THREADS(NUM_THREADS),
      .VEC_W      (VEC_W)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_i     (sync_all[b*LPB +: LPB]),
      .rise_i    (rise_all[b*LPB +: LPB]),
      .wr_stat_i (sel && !dec.is_vec && (dec.kind == KIND_STAT)),
      .wr_sense_i(sel && !dec.is_vec && (dec.kind == KIND_SENSE)),
      .wr_mask_i (sel && !dec.is_vec && (dec.kind == KIND_MASK)),
      .wr_vec_i  (sel && dec.is_vec),
      .line_i    (dec.line),
      .wdata_i   (wdata_i),
      .stat_o    (stat_b[b]),
      .sense_o   (sense_b[b]),
      .mask_o    (mask_b[b]),
      .vec_o     (vec_b[b]),
      .req_o     (req_b[b])
    );
  end

  assign stat_all  = stat_b;
  assign sense_all = sense_b;
  assign mask_all  = mask_b;
  assign vec_all   = vec_b;

  always_comb begin
    any_req = '0;
    for (int b = 0; b < NUM_BANKS; b++) any_req |= req_b[b];
  end
  assign trig_n_o = ~any_req;

  always_comb begin
    rd_val = '0;
    if (dec.hit) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (dec.bank == 2'(b)) begin
          if (dec.is_vec) begin
            rd_val = BUS_W'(vec_b[b][32'(dec.line)*VEC_W +: VEC_W]);
          end else begin
            case (dec.kind)
              KIND_STAT:  rd_val = stat_b[b];
              KIND_SENSE: rd_val = sense_b[b];
              KIND_MASK:  rd_val = mask_b[b];
              default:    rd_val = '0;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_o <= '0;
    else if (req_i && !we_i)   rdata_o <= rd_val;
  end
endmodule

// File: rtl/ext_irq_agg_chk.sv
module ext_irq_agg_chk #(
  parameter int unsigned NL    = 64,
  parameter int unsigned NT    = 4,
  parameter int unsigned VEC_W = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [31:0]         rdata_o,
  input logic [NT-1:0]       trig_n_o,
  input logic [NL-1:0]       stat_all,
  input logic [NL-1:0]       sense_all,
  input logic [NL-1:0]       mask_all,
  input logic [NL*VEC_W-1:0] vec_all,
  input logic [NL-1:0]       sync_all,
  input logic [NL-1:0]       rise_all
);
  logic [NL-1:0] vec_on, pend;

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      vec_on[i] = (vec_all[i*VEC_W +: VEC_W] != '0) && (32'(vec_all[i*VEC_W +: VEC_W]) <= NT);
    end
  end
  assign pend = stat_all & mask_all & vec_on;

  // R2
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  // R10
  mask_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_all == '0) |-> (&trig_n_o));

  // R11
  vec_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_on == '0) |-> (&trig_n_o));

  // R12
  idle_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |-> (&trig_n_o));

  for (genvar i = 0; i < NL; i++) begin : g_line
    // R7
    edge_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sense_all[i] && rise_all[i]) |=> stat_all[i]);

    // R5
    edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sense_all[i] && stat_all[i] && !(req_i && we_i)) |=> stat_all[i]);

    // R8
    level_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_all[i] && sync_all[i]) |=> stat_all[i]);
  end
endmodule

bind ext_irq_agg ext_irq_agg_chk #(
  .NL   (NUM_LINES),
  .NT   (NUM_THREADS),
  .VEC_W(VEC_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .rdata_o  (rdata_o),
  .trig_n_o (trig_n_o),
  .stat_all (stat_all),
  .sense_all(sense_all),
  .mask_all (mask_all),
  .vec_all  (vec_all),
  .sync_all (sync_all),
  .rise_all (rise_all)
);

// File: tb/sim_ext_irq_agg.sv
`timescale 1ns/1ps
module sim_ext_irq_agg;
  localparam int NB = 2;
  localparam int NT = 4;
  localparam int NL = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq = '0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [14:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NT-1:0] trig_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ext_irq_agg #(.NUM_BANKS(NB), .NUM_THREADS(NT)) u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .irq_i   (irq),
    .req_i   (req),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .trig_n_o(trig_n)
  );

  function automatic logic [14:0] a_stat(int b);  return 15'(8 * b);          endfunction
  function automatic logic [14:0] a_sense(int b); return 15'(64 + 8 * b);     endfunction
  function automatic logic [14:0] a_mask(int b);  return 15'(128 + 8 * b);    endfunction
  function automatic logic [14:0] a_vec(int b, int i); return 15'(4096 * (b + 1) + 4 * i); endfunction

  function automatic logic [NT-1:0] exp_trig(int v);
    logic [NT-1:0] r;
    r = '1;
    if (v >= 1 && v <= NT) r[v-1] = 1'b0;
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [14:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [14:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 trig", 32'(trig_n), 32'hF);
    chk("R1 rdata", rdata, 32'h0);
    rd(a_stat(0), d);   chk("R1 stat0", d, 0);
    rd(a_sense(1), d);  chk("R1 sense1", d, 0);
    rd(a_mask(0), d);   chk("R1 mask0", d, 0);
    rd(a_vec(1, 31), d); chk("R1 vec", d, 0);

    // sweep every line, edge mode, all routing codes
    for (int n = 0; n < NL; n++) begin
      int b, i, v;
      b = n >> 5; i = n & 31; v = n % 8;
      wr(a_vec(b, i), 32'(v));
      wr(a_mask(b), 32'(1) << i);
      irq[n] = 1'b1;
      idle(2);
      chk("R4 not yet", 32'(trig_n), 32'hF);
      idle(1);
      chk("R11 route", 32'(trig_n), 32'(exp_trig(v)));
      rd(a_stat(b), d);
      chk("R3 bit position", d, 32'(1) << i);
      irq[n] = 1'b0;
      idle(4);
      rd(a_stat(b), d);
      chk("R5 fall keeps", d, 32'(1) << i);
      wr(a_stat(b), 32'(1) << i);
      chk("R6 ack trig", 32'(trig_n), 32'hF);
      rd(a_stat(b), d);
      chk("R6 ack stat", d, 0);
      wr(a_mask(b), 0);
      wr(a_vec(b, i), 0);
    end

    // R10 masked line still recorded
    wr(a_vec(0, 3), 2);
    irq[3] = 1'b1;
    idle(3);
    chk("R10 blocked", 32'(trig_n), 32'hF);
    rd(a_stat(0), d);
    chk("R10 recorded", d, 32'h8);
    wr(a_mask(0), 32'h8);
    chk("R12 immediate", 32'(trig_n), 32'hD);
    wr(a_stat(0), 0);
    chk("R6 write zero", 32'(trig_n), 32'hD);
    irq[3] = 1'b0;
    wr(a_stat(0), 32'h8);
    chk("R6 ack", 32'(trig_n), 32'hF);
    wr(a_stat(0), 32'h8);
    chk("R6 retrigger", 32'(trig_n), 32'hD);
    idle(4);

    // R7 rising edge and toggle in the same cycle
    irq[3] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(a_stat(0), 32'h8);
    chk("R7 trig", 32'(trig_n), 32'hD);
    rd(a_stat(0), d);
    chk("R7 stat", d, 32'h8);
    irq[3] = 1'b0;
    wr(a_stat(0), 32'h8);
    chk("R7 ack", 32'(trig_n), 32'hF);

    // level line 40: bank 1 bit 8, thread 3
    wr(a_sense(1), 32'h100);
    rd(a_sense(1), d);
    chk("R13 sense", d, 32'h100);
    wr(a_vec(1, 8), 4);
    wr(a_mask(1), 32'h100);
    irq[40] = 1'b1;
    idle(2);
    chk("R8 not yet", 32'(trig_n), 32'hF);
    idle(1);
    chk("R8 high", 32'(trig_n), 32'h7);
    irq[40] = 1'b0;
    idle(2);
    chk("R8 still high", 32'(trig_n), 32'h7);
    idle(1);
    chk("R8 low", 32'(trig_n), 32'hF);
    wr(a_stat(1), 32'h100);
    chk("R9 force", 32'(trig_n), 32'h7);
    idle(1);
    chk("R9 release low input", 32'(trig_n), 32'hF);
    irq[40] = 1'b1;
    idle(3);
    wr(a_stat(1), 32'h100);
    chk("R9 force high", 32'(trig_n), 32'h7);
    idle(5);
    chk("R9 held", 32'(trig_n), 32'h7);
    irq[40] = 1'b0;
    idle(2);
    chk("R9 held until low", 32'(trig_n), 32'h7);
    idle(1);
    chk("R9 released", 32'(trig_n), 32'hF);

    // back to edge mode, held-high input acknowledged
    wr(a_sense(1), 0);
    irq[40] = 1'b1;
    idle(3);
    chk("R13 edge raise", 32'(trig_n), 32'h7);
    wr(a_stat(1), 32'h100);
    chk("R13 edge ack", 32'(trig_n), 32'hF);
    idle(4);
    chk("R13 no re-raise", 32'(trig_n), 32'hF);
    irq[40] = 1'b0;
    idle(4);

    // R2 unmapped accesses
    wr(15'h0C0, 32'hFFFF_FFFF);
    wr(15'h010, 32'hFFFF_FFFF);
    wr(15'h0090, 32'hFFFF_FFFF);
    wr(15'h3000, 32'hFFFF_FFFF);
    wr(15'h1002, 32'hFFFF_FFFF);
    chk("R2 no stray trig", 32'(trig_n), 32'hF);
    rd(a_mask(0), d);    chk("R2 mask0 kept", d, 32'h8);
    rd(a_mask(1), d);    chk("R2 mask1 kept", d, 32'h100);
    rd(a_stat(0), d);    chk("R2 stat0 kept", d, 0);
    rd(15'h0C0, d);      chk("R2 hole", d, 0);
    rd(15'h010, d);      chk("R2 bank range", d, 0);
    rd(15'h002, d);      chk("R2 misaligned", d, 0);
    rd(a_vec(1, 8), d);  chk("R2 vec readback", d, 4);
    rd(a_vec(0, 0), d);  chk("R2 vec0 untouched", d, 0);
    idle(2);
    chk("R2 rdata held", rdata, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule